// File: doc/BRIEF.md
# Shared Status Pin Mode Capture and Indicator Driver

This block owns one bidirectional board pin that does two jobs in sequence. Straight after reset it keeps the pin's output driver off. An external converter digitizes the voltage that a resistor ladder sets on the pin into a 4-bit code. The block samples that code on every millisecond tick and latches it as the operating mode once the code has held steady long enough. From then on the mode stays frozen until the next reset, and the pin becomes an output that drives an indicator LED.

The LED pattern follows status from the power sequencer. A symmetric slow blink of roughly 1.5 Hz means the sequencer is searching for a valid load. A constant on means power has been granted. A denial strobe starts a 2-second burst of 10 Hz blinking, and that burst outranks every other pattern. The analog ladder and the comparators that digitize it are outside this block.

Top module: `status_pin_ctrl`

## Requirements
- R1: While reset is asserted and until mode capture completes, `pin_oe`, `pin_drive` and `mode_valid` are 0 and `mode_code` is 0.
- R2: The mode is captured when `pin_level` has had the same value on STABLE_TICKS (default 8) consecutive `ms_tick` pulses. A differing value restarts the count, and the captured code equals that stable value.
- R3: `pin_oe` rises in the same cycle as `mode_valid` and stays high until the next reset. `pin_drive` is 0 whenever `pin_oe` is 0.
- R4: After capture, changes on `pin_level` leave `mode_code` unchanged. A new reset performs a fresh capture.
- R5: With `searching` high, `powered` low and no burst active, the LED blinks with SLOW_HALF_MS (default 333) ticks on then the same number off, starting in the on phase.
- R6: With `powered` high and no burst active, `pin_drive` is steadily 1.
- R7: A `deny_strobe` pulse starts a burst of BURST_MS (default 2000) ticks. During the burst the LED blinks FAST_HALF_MS (default 50) ticks on and 50 off, starting on, whatever `powered` and `searching` say.
- R8: A `deny_strobe` during an active burst reloads the full BURST_MS window.
- R9: When a burst ends with `searching` high, the slow pattern starts again from its on phase.
- R10: With none of `searching`, `powered` or an active burst, `pin_drive` is 0 after capture.
- R11: `pin_drive` is registered and reflects the inputs and state one clock after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pin_level | input | 4 | Digitized level of the pin while it is undriven |
| searching | input | 1 | Sequencer is looking for a valid load |
| powered | input | 1 | Sequencer has granted power |
| deny_strobe | input | 1 | One-cycle pulse on a classification denial |
| pin_oe | output | 1 | Output enable of the pin driver |
| pin_drive | output | 1 | Value driven on the pin for the LED |
| mode_code | output | 4 | Latched operating mode |
| mode_valid | output | 1 | Mode capture has completed |

## Verification
The checks target the two failure classes in this block: a capture counter that counts wrongly and a blink or burst timer that runs at the wrong speed. A capture counter that is off by one shows up at the ports one tick early or late, as a change in `pin_oe`. A wrong reset of the count on a level change latches the wrong code, and `mode_code` shows it at once. A timer error appears at `pin_drive` as the wrong phase when the output is sampled in the middle of a phase. A burst that does not reload shows as a steady on, about 2 seconds after the first denial, where blinking is expected. Sampling in mid-phase leaves room for the one-cycle output register.

// File: rtl/status_pin_pkg.sv
package status_pin_pkg;
  typedef enum logic [1:0] {
    LED_OFF  = 2'd0,
    LED_SLOW = 2'd1,
    LED_FAST = 2'd2,
    LED_ON   = 2'd3
  } led_src_e;
endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sp_mode_capture.sv
module sp_mode_capture #(
  parameter int MODE_W       = 4,
  parameter int STABLE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] level,
  output logic              done,
  output logic [MODE_W-1:0] mode
);
  localparam int CNT_W = $clog2(STABLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_TICKS - 1);

  logic [MODE_W-1:0] samp_q, samp_d, mode_q, mode_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;

  always_comb begin
    samp_d = samp_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    mode_d = mode_q;
    if (tick && !done_q) begin
      if ((cnt_q != '0) && (level == samp_q)) begin
        if (cnt_q == LAST) begin
          done_d = 1'b1;
          mode_d = level;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        samp_d = level;
        cnt_d  = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      mode_q <= '0;
    end else begin
      samp_q <= samp_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      mode_q <= mode_d;
    end
  end

  assign done = done_q;
  assign mode = mode_q;
endmodule

// File: rtl/sp_burst_timer.sv
module sp_burst_timer #(
  parameter int BURST_MS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic active
);
  localparam int CNT_W = $clog2(BURST_MS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)                      cnt_d = CNT_W'(BURST_MS);
    else if (tick && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/sp_blinker.sv
module sp_blinker #(
  parameter int HALF_MS = 333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic led
);
  localparam int CNT_W = (HALF_MS > 1) ? $clog2(HALF_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_MS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             led_q, led_d;

  always_comb begin
    cnt_d = cnt_q;
    led_d = led_q;
    if (!en) begin
      cnt_d = '0;
      led_d = 1'b1;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        led_d = ~led_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      led_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      led_q <= led_d;
    end
  end

  assign led = led_q;
endmodule

// File: rtl/status_pin_ctrl.sv
module status_pin_ctrl #(
  parameter int MODE_W       = 4,
  parameter int STABLE_TICKS = 8,
  parameter int SLOW_HALF_MS = 333,
  parameter int FAST_HALF_MS = 50,
  parameter int BURST_MS     = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [MODE_W-1:0] pin_level,
  input  logic              searching,
  input  logic              powered,
  input  logic              deny_strobe,
  output logic              pin_oe,
  output logic              pin_drive,
  output logic [MODE_W-1:0] mode_code,
  output logic              mode_valid
);
  import status_pin_pkg::*;

  logic     rst_n_i;
  logic     cap_done;
  logic     burst_act;
  logic     slow_en, slow_led, fast_led;
  led_src_e src;
  logic     drive_q, drive_d;

  sp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sp_mode_capture #(
    .MODE_W       (MODE_W),
    .STABLE_TICKS (STABLE_TICKS)
  ) u_cap (
    .clk   (clk),
    .rst_n (rst_n_i),
    .tick  (ms_tick),
    .level (pin_level),
    .done  (cap_done),
    .mode  (mode_code)
  );

  sp_burst_timer #(
    .BURST_MS (BURST_MS)
  ) u_burst (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .tick   (ms_tick),
    .start  (deny_strobe),
    .active (burst_act)
  );

  assign slow_en = searching && !powered && !burst_act;

  sp_blinker #(.HALF_MS(SLOW_HALF_MS)) u_slow (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en    (slow_en),
    .tick  (ms_tick),
    .led   (slow_led)
  );

  sp_blinker #(.HALF_MS(FAST_HALF_MS)) u_fast (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en    (burst_act),
    .tick  (ms_tick),
    .led   (fast_led)
  );

  always_comb begin
    if (burst_act)      src = LED_FAST;
    else if (powered)   src = LED_ON;
    else if (searching) src = LED_SLOW;
    else                src = LED_OFF;
  end

  always_comb begin
    unique case (src)
      LED_FAST: drive_d = fast_led;
      LED_SLOW: drive_d = slow_led;
      LED_ON:   drive_d = 1'b1;
      default:  drive_d = 1'b0;
    endcase
    drive_d = drive_d & cap_done;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) drive_q <= 1'b0;
    else          drive_q <= drive_d;
  end

  assign pin_oe     = cap_done;
  assign mode_valid = cap_done;
  assign pin_drive  = drive_q;
endmodule

// File: rtl/status_pin_ctrl_chk.sv
module status_pin_ctrl_chk #(
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ms_tick,
  input logic              powered,
  input logic              deny_strobe,
  input logic              burst_act,
  input logic              pin_oe,
  input logic              pin_drive,
  input logic [MODE_W-1:0] mode_code,
  input logic              mode_valid
);
  // R3
  drive_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_drive);

  // R3
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |=> pin_oe);

  // R4
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> $stable(mode_code));

  // R2
  capture_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(ms_tick));

  // R6
  steady_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && !burst_act && pin_oe) |=> pin_drive);

  // R7
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny_strobe |=> burst_act);
endmodule

bind status_pin_ctrl status_pin_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ms_tick     (ms_tick),
  .powered     (powered),
  .deny_strobe (deny_strobe),
  .burst_act   (burst_act),
  .pin_oe      (pin_oe),
  .pin_drive   (pin_drive),
  .mode_code   (mode_code),
  .mode_valid  (mode_valid)
);

// File: tb/status_pin_ctrl_tb.sv
module status_pin_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ms_tick;
  logic [3:0] pin_level;
  logic       searching, powered, deny_strobe;
  logic       pin_oe, pin_drive, mode_valid;
  logic [3:0] mode_code;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  status_pin_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .pin_level   (pin_level),
    .searching   (searching),
    .powered     (powered),
    .deny_strobe (deny_strobe),
    .pin_oe      (pin_oe),
    .pin_drive   (pin_drive),
    .mode_code   (mode_code),
    .mode_valid  (mode_valid)
  );

  typedef struct packed {
    logic        srch;
    logic        pwr;
    logic        deny;
    logic [15:0] wait_c;
    logic        exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 16'd100,  1'b1},  // R5 slow on phase
    '{1'b1, 1'b0, 1'b0, 16'd333,  1'b0},  // R5 slow off phase
    '{1'b1, 1'b0, 1'b0, 16'd333,  1'b1},  // R5 slow on again
    '{1'b0, 1'b1, 1'b0, 16'd5,    1'b1},  // R6 steady on
    '{1'b0, 1'b1, 1'b0, 16'd500,  1'b1},  // R6 still on
    '{1'b0, 1'b0, 1'b0, 16'd5,    1'b0},  // R10 idle off
    '{1'b1, 1'b0, 1'b1, 16'd25,   1'b1},  // R7 fast on
    '{1'b1, 1'b0, 1'b0, 16'd50,   1'b0},  // R7 fast off
    '{1'b1, 1'b0, 1'b0, 16'd50,   1'b1},  // R7 fast on
    '{1'b1, 1'b0, 1'b0, 16'd2045, 1'b1},  // R9 slow restarts on
    '{1'b1, 1'b0, 1'b0, 16'd333,  1'b0},  // R9 slow off phase
    '{1'b0, 1'b0, 1'b0, 16'd5,    1'b0}   // R10 idle off
  };

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; pin_level = 4'hA;
    searching = 1'b0; powered = 1'b0; deny_strobe = 1'b0;
    step(3);
    // R1 reset state
    chk({3'b0, pin_oe}, 4'h0, "R1 oe");
    chk({3'b0, pin_drive}, 4'h0, "R1 drive");
    chk({3'b0, mode_valid}, 4'h0, "R1 valid");
    chk(mode_code, 4'h0, "R1 mode");
    rst_n = 1'b1;
    step(4);

    // R2 count restarts on a level change
    repeat (7) tick_once();
    chk({3'b0, mode_valid}, 4'h0, "R2 not yet valid");
    pin_level = 4'h5;
    repeat (7) tick_once();
    chk({3'b0, pin_oe}, 4'h0, "R3 oe off before capture");
    chk({3'b0, mode_valid}, 4'h0, "R2 restarted count");
    tick_once();
    chk({3'b0, mode_valid}, 4'h1, "R2 captured");
    chk(mode_code, 4'h5, "R2 captured code");
    chk({3'b0, pin_oe}, 4'h1, "R3 oe with capture");

    // R4 frozen mode, free-running ticks from here
    pin_level = 4'h3;
    ms_tick = 1'b1;
    step(20);
    chk(mode_code, 4'h5, "R4 mode frozen");
    chk({3'b0, pin_drive}, 4'h0, "R10 idle after capture");

    // table walk: R5 R6 R7 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      searching = VECS[i].srch;
      powered   = VECS[i].pwr;
      if (VECS[i].deny) begin
        deny_strobe = 1'b1;
        step(1);
        deny_strobe = 1'b0;
        step(int'(VECS[i].wait_c) - 1);
      end else begin
        step(int'(VECS[i].wait_c));
      end
      chk({3'b0, pin_drive}, {3'b0, VECS[i].exp}, $sformatf("R5-R10 table row %0d", i));
    end

    // R7 burst outranks powered
    searching = 1'b1; powered = 1'b1;
    deny_strobe = 1'b1; step(1); deny_strobe = 1'b0;
    step(74);
    chk({3'b0, pin_drive}, 4'h0, "R7 burst over powered off phase");
    step(50);
    chk({3'b0, pin_drive}, 4'h1, "R7 burst over powered on phase");

    // R8 second denial reloads the window
    step(1375);
    deny_strobe = 1'b1; step(1); deny_strobe = 1'b0;
    step(1074);
    chk({3'b0, pin_drive}, 4'h0, "R8 burst still active");
    step(1000);
    chk({3'b0, pin_drive}, 4'h1, "R8 burst ended then steady");

    // R4 fresh capture after a new reset
    ms_tick = 1'b0; rst_n = 1'b0; pin_level = 4'h9;
    step(2);
    chk({3'b0, pin_oe}, 4'h0, "R1 oe cleared by reset");
    chk({3'b0, pin_drive}, 4'h0, "R3 drive cleared by reset");
    rst_n = 1'b1;
    step(4);
    ms_tick = 1'b1;
    step(30);
    chk(mode_code, 4'h9, "R4 recaptured code");
    chk({3'b0, pin_oe}, 4'h1, "R3 oe after recapture");
    // R11 drive registered: changes one clock after powered
    searching = 1'b0; powered = 1'b0;
    step(3);
    @(posedge clk);
    powered <= 1'b1;
    @(negedge clk);
    chk({3'b0, pin_drive}, 4'h0, "R11 not yet updated");
    @(negedge clk);
    chk({3'b0, pin_drive}, 4'h1, "R11 updated next clock");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule